// File: doc/BRIEF.md
# Raster Timing Generator with Staged Power Sequencing

This block drives the raster timing of a parallel RGB panel. From a set of configuration words it produces horizontal and vertical sync, a data-enable strobe and the current pixel and line position. It also gates the pixel data stream. A small register port holds the timing fields, the sync polarities and an output-format code that a downstream formatter decodes. The same port holds stage request bits, a stage status word and an interrupt enable.

Bring-up and shutdown are staged. A sequencer state machine with the states ST_OFF, ST_CLK, ST_SYNC and ST_DISP walks the three stages: pixel clock, sync generation and display data. The transitions are:

- ST_OFF to ST_CLK: the clock request is set.
- ST_CLK to ST_OFF: the clock request is cleared.
- ST_CLK to ST_SYNC: the sync request is set at a frame boundary.
- ST_SYNC to ST_CLK: the sync request is cleared at a frame boundary.
- ST_SYNC to ST_DISP: the display request is set at a frame boundary.
- ST_DISP to ST_SYNC: the display request is cleared at a frame boundary.

Requests are held, so software may raise or drop several bits at once. The sequencer then honours the order by itself. Each frame begins with a start-of-frame pulse, which sets a sticky flag. The flag is read-to-clear and feeds a maskable interrupt.

Top module: `lcd_timing_seq`

## Requirements
- R1: After reset the status word is 0, and hsync, vsync, de, pix_out, irq, h_pos and v_pos are all 0.
- R2: Word addresses 0 to 4 read back the last value written. The layout of each word is as follows.
  - Word 0 holds hsync width-1 in [11:0] and vsync width-1 in [27:16].
  - Word 1 holds the vertical front porch-1 in [11:0] and the vertical back porch, not biased, in [27:16].
  - Word 2 holds the horizontal front porch-1 in [11:0] and the horizontal back porch-1 in [27:16].
  - Word 3 holds the active pixels-1 in [11:0] and the active lines-1 in [27:16].
  - Word 4 holds the hsync invert in bit 0, the vsync invert in bit 1 and the output-format code in [11:8].
- R3: A line runs in this order: hsync (active for the sync width), back porch, active pixels (de high when the line is also active), front porch. Its length is the sum of the four.
- R4: A frame runs in this order: vsync lines, back-porch lines (exactly the stored count), active lines, front-porch lines.
- R5: With bit 0 (or bit 1) of word 4 set, hsync (or vsync) is driven active-low.
- R6: Status bit 0 (clock) follows the clock request one cycle after the write to word 5 (bits set) or word 6 (bits cleared). h_pos and v_pos advance only while the clock stage is on, and are held at 0 otherwise.
- R7: Status bits 1 (sync) and 2 (display) change only at a frame boundary. They are first seen with h_pos = v_pos = 0. Sync rises only with the clock stage on, and display rises only with sync on. Shutdown runs display, then sync, then clock. With the clock started at position 0 and sync already requested, sync rises 40 cycles later for a 40-pixel frame.
- R8: With the sync stage off, hsync and vsync sit at their inactive level and de is 0. pix_out equals pix_in only when de is high and the display stage is on, and is 0 otherwise.
- R9: sof is a one-cycle pulse at h_pos = v_pos = 0 while the sync stage is on.
- R10: sof sets a sticky flag, read as bit 0 of word 10. A read strobe on word 10 clears the flag, and a new sof wins over a clear in the same cycle. Writing 1 to bit 0 of word 8 enables the interrupt, and writing 1 to bit 0 of word 9 disables it. irq is high when the flag and the enable are both set.
- R11: out_mode presents bits [11:8] of word 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flag on word 10) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pix_in | input | 24 | Pixel stream from the fetch path |
| pix_out | output | 24 | Gated pixel data to the panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| h_pos | output | 14 | Pixel position within the line |
| v_pos | output | 14 | Line position within the frame |
| sof | output | 1 | Start-of-frame pulse |
| irq | output | 1 | Interrupt request |
| out_mode | output | 4 | Output-format code |

## Verification
The bench programs a 8-pixel by 5-line raster and walks whole frames pixel by pixel. The back-porch line count is set to 1. A design that biased that field like its neighbours would move the active lines down by one and fail the de checks. It requests sync before the clock runs and times the sync rise from clock start. A design that ignored the order, or switched stages outside a frame boundary, would show a status change at the wrong count or at a nonzero position. It also reads the flag in the cycle after a start of frame, toggles the interrupt enable, and shuts all stages down with one write. Together these expose a flag that is not sticky, a mask that hides the flag itself, or a shutdown that drops the clock while sync still runs.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    localparam int ADDR_W = 4;
    localparam int NSTG   = 3;

    localparam logic [ADDR_W-1:0] A_SYNCW  = 4'd0;
    localparam logic [ADDR_W-1:0] A_VPORCH = 4'd1;
    localparam logic [ADDR_W-1:0] A_HPORCH = 4'd2;
    localparam logic [ADDR_W-1:0] A_ACTIVE = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd4;
    localparam logic [ADDR_W-1:0] A_ON     = 4'd5;
    localparam logic [ADDR_W-1:0] A_OFF    = 4'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd7;
    localparam logic [ADDR_W-1:0] A_IEN    = 4'd8;
    localparam logic [ADDR_W-1:0] A_IDIS   = 4'd9;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 4'd10;

    localparam int NCFG = 5;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CLK,
        ST_SYNC,
        ST_DISP
    } stage_e;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
    import lcd_tg_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    input  logic [NSTG-1:0]           stat,
    input  logic                      sof,
    output logic [NCFG-1:0][DW-1:0]   cfg,
    output logic [NSTG-1:0]           req_nxt,
    output logic                      irq_mask,
    output logic                      irq
);
    logic [NSTG-1:0] req;
    logic            sof_flag;

    // Held stage requests; on-bits set, off-bits cleared, same-cycle view
    always_comb begin
        req_nxt = req;
        if (bus_wr && bus_addr == A_ON)
            req_nxt = req_nxt | bus_wdata[NSTG-1:0];
        if (bus_wr && bus_addr == A_OFF)
            req_nxt = req_nxt & ~bus_wdata[NSTG-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg      <= '0;
            req      <= '0;
            irq_mask <= 1'b0;
            sof_flag <= 1'b0;
        end else begin
            for (int i = 0; i < NCFG; i++)
                if (bus_wr && bus_addr == ADDR_W'(i))
                    cfg[i] <= bus_wdata;
            req <= req_nxt;
            if (bus_wr && bus_addr == A_IEN && bus_wdata[0])
                irq_mask <= 1'b1;
            else if (bus_wr && bus_addr == A_IDIS && bus_wdata[0])
                irq_mask <= 1'b0;
            if (sof)
                sof_flag <= 1'b1;
            else if (bus_rd && bus_addr == A_ISTAT)
                sof_flag <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCFG; i++)
            if (bus_addr == ADDR_W'(i))
                bus_rdata = cfg[i];
        if (bus_addr == A_ON)    bus_rdata = DW'(req);
        if (bus_addr == A_STAT)  bus_rdata = DW'(stat);
        if (bus_addr == A_IEN)   bus_rdata = DW'(irq_mask);
        if (bus_addr == A_ISTAT) bus_rdata = DW'(sof_flag);
    end

    assign irq = sof_flag & irq_mask;
endmodule

// File: rtl/lcd_tg_seq.sv
module lcd_tg_seq
    import lcd_tg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] req_nxt,
    input  logic            frame_end,
    output logic [NSTG-1:0] stat,
    output logic            run,
    output logic            run_nxt
);
    stage_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_OFF:  if (req_nxt[0]) st_nxt = ST_CLK;
            ST_CLK: begin
                if (!req_nxt[0])                   st_nxt = ST_OFF;
                else if (req_nxt[1] && frame_end)  st_nxt = ST_SYNC;
            end
            ST_SYNC: begin
                if (!req_nxt[1] && frame_end)      st_nxt = ST_CLK;
                else if (req_nxt[2] && frame_end)  st_nxt = ST_DISP;
            end
            ST_DISP: if (!req_nxt[2] && frame_end) st_nxt = ST_SYNC;
        endcase
    end

    always_comb begin
        stat = '0;
        unique case (st)
            ST_OFF:  stat = 3'b000;
            ST_CLK:  stat = 3'b001;
            ST_SYNC: stat = 3'b011;
            ST_DISP: stat = 3'b111;
        endcase
        run     = (st != ST_OFF);
        run_nxt = (st_nxt != ST_OFF);
    end
endmodule

// File: rtl/lcd_tg_raster.sv
module lcd_tg_raster #(
    parameter int CW = 12,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] hsw_m1,
    input  logic [CW-1:0] hbp_m1,
    input  logic [CW-1:0] hact_m1,
    input  logic [CW-1:0] hfp_m1,
    input  logic [CW-1:0] vsw_m1,
    input  logic [CW-1:0] vbp,
    input  logic [CW-1:0] vact_m1,
    input  logic [CW-1:0] vfp_m1,
    input  logic          run,
    input  logic          run_nxt,
    input  logic          sync_on,
    input  logic          disp_on,
    input  logic          hs_inv,
    input  logic          vs_inv,
    input  logic [PW-1:0] pix_in,
    output logic [CW+1:0] h_pos,
    output logic [CW+1:0] v_pos,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [PW-1:0] pix_out,
    output logic          sof,
    output logic          frame_end
);
    localparam int TW = CW + 2;

    logic [TW-1:0] h_se, h_as, h_ae, h_last;
    logic [TW-1:0] v_se, v_as, v_ae, v_last;
    logic          line_end;

    // Segment boundaries: sync, back porch, active, front porch
    assign h_se   = TW'(hsw_m1) + TW'(1);
    assign h_as   = h_se + TW'(hbp_m1) + TW'(1);
    assign h_ae   = h_as + TW'(hact_m1) + TW'(1);
    assign h_last = h_ae + TW'(hfp_m1);
    assign v_se   = TW'(vsw_m1) + TW'(1);
    assign v_as   = v_se + TW'(vbp);
    assign v_ae   = v_as + TW'(vact_m1) + TW'(1);
    assign v_last = v_ae + TW'(vfp_m1);

    assign line_end  = (h_pos >= h_last);
    assign frame_end = line_end && (v_pos >= v_last);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || !run_nxt) begin
            h_pos <= '0;
            v_pos <= '0;
        end else if (line_end) begin
            h_pos <= '0;
            v_pos <= frame_end ? '0 : v_pos + TW'(1);
        end else begin
            h_pos <= h_pos + TW'(1);
        end
    end

    always_comb begin
        hsync   = (sync_on && h_pos < h_se) ^ hs_inv;
        vsync   = (sync_on && v_pos < v_se) ^ vs_inv;
        de      = sync_on && (h_pos >= h_as) && (h_pos < h_ae)
                          && (v_pos >= v_as) && (v_pos < v_ae);
        pix_out = (disp_on && de) ? pix_in : '0;
        sof     = sync_on && (h_pos == '0) && (v_pos == '0);
    end
endmodule

// File: rtl/lcd_timing_seq.sv
module lcd_timing_seq
    import lcd_tg_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [PW-1:0] pix_in,
    output logic [PW-1:0] pix_out,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [CW+1:0] h_pos,
    output logic [CW+1:0] v_pos,
    output logic          sof,
    output logic          irq,
    output logic [3:0]    out_mode
);
    localparam int HI     = DW / 2;
    localparam int MODE_L = 8;

    logic [NCFG-1:0][DW-1:0] cfg;
    logic [NSTG-1:0]         req_nxt;
    logic [NSTG-1:0]         stat;
    logic                    run, run_nxt, frame_end, irq_mask;
    logic                    hs_inv, vs_inv;

    assign hs_inv   = cfg[A_MODE][0];
    assign vs_inv   = cfg[A_MODE][1];
    assign out_mode = cfg[A_MODE][MODE_L+3:MODE_L];

    lcd_tg_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat(stat), .sof(sof), .cfg(cfg), .req_nxt(req_nxt),
        .irq_mask(irq_mask), .irq(irq)
    );

    lcd_tg_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_nxt(req_nxt), .frame_end(frame_end),
        .stat(stat), .run(run), .run_nxt(run_nxt)
    );

    lcd_tg_raster #(.CW(CW), .PW(PW)) u_raster (
        .clk(clk), .rst_n(rst_n),
        .hsw_m1 (cfg[A_SYNCW][CW-1:0]),  .vsw_m1 (cfg[A_SYNCW][HI+CW-1:HI]),
        .vfp_m1 (cfg[A_VPORCH][CW-1:0]), .vbp    (cfg[A_VPORCH][HI+CW-1:HI]),
        .hfp_m1 (cfg[A_HPORCH][CW-1:0]), .hbp_m1 (cfg[A_HPORCH][HI+CW-1:HI]),
        .hact_m1(cfg[A_ACTIVE][CW-1:0]), .vact_m1(cfg[A_ACTIVE][HI+CW-1:HI]),
        .run(run), .run_nxt(run_nxt), .sync_on(stat[1]), .disp_on(stat[2]),
        .hs_inv(hs_inv), .vs_inv(vs_inv), .pix_in(pix_in),
        .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_out(pix_out), .sof(sof), .frame_end(frame_end)
    );
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker #(
    parameter int CW = 12,
    parameter int PW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    stat,
    input logic [CW+1:0] h_pos,
    input logic [CW+1:0] v_pos,
    input logic          hsync,
    input logic          vsync,
    input logic          de,
    input logic [PW-1:0] pix_out,
    input logic          sof,
    input logic          irq,
    input logic          irq_mask,
    input logic          bus_wr,
    input logic          hs_inv,
    input logic          vs_inv
);
    a_r6_counters_held: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[0] |-> (h_pos == '0 && v_pos == '0));

    a_r7_sync_rise_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> (h_pos == '0 && v_pos == '0));

    a_r8_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[1] |-> (!de && hsync == hs_inv && vsync == vs_inv));

    a_r8_pix_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[2] |-> (pix_out == '0));

    a_r9_sof_single: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    a_r10_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && irq_mask && !bus_wr) |=> irq);
endmodule

bind lcd_timing_seq lcd_tg_checker #(.CW(CW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stat), .h_pos(h_pos), .v_pos(v_pos),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .sof(sof),
    .irq(irq), .irq_mask(irq_mask), .bus_wr(bus_wr),
    .hs_inv(hs_inv), .vs_inv(vs_inv)
);

// File: tb/lcd_timing_seq_test.sv
module lcd_timing_seq_test;
    localparam int CW = 12;
    localparam int PW = 24;
    localparam int DW = 32;
    localparam logic [3:0] A_STAT = 4'd7;
    localparam int LINE = 8;
    localparam int FRAME = 40;

    // {address, data}: 2-pixel hsync, hbp 1, 4 active, hfp 1;
    // 1-line vsync, vbp 1 (unbiased), 2 active lines, vfp 1; mode 5
    localparam logic [35:0] TBL [5] = '{
        {4'd0, 32'h0000_0001},
        {4'd1, 32'h0001_0000},
        {4'd2, 32'h0000_0000},
        {4'd3, 32'h0001_0003},
        {4'd4, 32'h0000_0500}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = A_STAT;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [PW-1:0] pix_in = 24'hABCDEF;
    logic [PW-1:0] pix_out;
    logic hsync, vsync, de, sof, irq;
    logic [CW+1:0] h_pos, v_pos;
    logic [3:0] out_mode;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    lcd_timing_seq #(.CW(CW), .PW(PW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_in(pix_in), .pix_out(pix_out), .hsync(hsync), .vsync(vsync),
        .de(de), .h_pos(h_pos), .v_pos(v_pos), .sof(sof), .irq(irq),
        .out_mode(out_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = A_STAT;
        #1;
    endtask

    task automatic rd_clear(output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = 4'd10;
        #1;
        d = bus_rdata;
        tick();
        bus_rd = 1'b0; bus_addr = A_STAT;
        #1;
    endtask

    // Walk one frame from h=0,v=0 and compare against the programmed raster
    task automatic walk_frame(input bit disp);
        for (int i = 0; i < FRAME; i++) begin
            int eh, ev;
            bit ehs, evs, ede;
            eh = i % LINE; ev = i / LINE;
            ehs = (eh < 2); evs = (ev < 1);
            ede = (eh >= 3 && eh < 7) && (ev >= 2 && ev < 4);
            chk(h_pos == 14'(eh) && v_pos == 14'(ev), "R3/R4 position",
                {h_pos[13:0], 2'b0, v_pos[13:0]}, 32'(eh) << 16 | 32'(ev));
            chk(hsync == ehs, "R3 hsync", 32'(hsync), 32'(ehs));
            chk(vsync == evs, "R4 vsync", 32'(vsync), 32'(evs));
            chk(de == ede, "R3/R4 de", 32'(de), 32'(ede));
            chk(pix_out == ((disp && ede) ? pix_in : '0), "R8 pix_out",
                32'(pix_out), (disp && ede) ? 32'(pix_in) : 32'h0);
            chk(sof == (i == 0), "R9 sof", 32'(sof), 32'(i == 0));
            if (i == 1) chk(irq == 1'b1, "R10 irq after sof", 32'(irq), 32'h1);
            tick();
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;

        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(bus_rdata[2:0] == 3'b000, "R1 status", bus_rdata, 0);
        chk(!hsync && !vsync && !de, "R1 sync/de", {hsync, vsync, de}, 0);
        chk(pix_out == '0 && !irq, "R1 pix/irq", 32'(pix_out), 0);
        chk(h_pos == '0 && v_pos == '0, "R1 position", 32'(h_pos), 0);

        // R2 table: write, then read back
        for (int k = 0; k < 5; k++) wr(TBL[k][35:32], TBL[k][31:0]);
        for (int k = 0; k < 5; k++) begin
            bus_addr = TBL[k][35:32];
            #1;
            chk(bus_rdata == TBL[k][31:0], "R2 readback", bus_rdata, TBL[k][31:0]);
        end
        bus_addr = A_STAT;
        #1;
        chk(out_mode == 4'd5, "R11 out_mode", 32'(out_mode), 32'd5);

        // R7 sync request while the clock is off has no effect
        wr(4'd8, 32'h1);
        wr(4'd5, 32'h2);
        repeat (20) tick();
        chk(bus_rdata[2:0] == 3'b000, "R7 sync held off", bus_rdata, 0);
        chk(h_pos == '0, "R6 counters idle", 32'(h_pos), 0);

        // R6 clock stage on one cycle after write
        wr(4'd5, 32'h1);
        chk(bus_rdata[2:0] == 3'b001, "R6 clock on", bus_rdata, 32'h1);
        chk(h_pos == '0, "R6 start at 0", 32'(h_pos), 0);
        chk(!hsync && !de, "R8 sync off levels", {hsync, de}, 0);
        repeat (3) tick();
        chk(h_pos == 14'd3, "R6 counting", 32'(h_pos), 32'd3);
        n = 3;
        while (!bus_rdata[1] && n < 200) begin tick(); n++; end
        chk(n == FRAME, "R7 sync rise delay", 32'(n), 32'(FRAME));
        chk(h_pos == '0 && v_pos == '0, "R7 sync at origin", 32'(h_pos), 0);
        chk(!irq, "R9 no sof before sync", 32'(irq), 0);

        walk_frame(1'b0);

        // R7 display stage on at next boundary
        wr(4'd5, 32'h4);
        n = 0;
        while (!bus_rdata[2] && n < 200) begin tick(); n++; end
        chk(bus_rdata[2:0] == 3'b111, "R7 display on", bus_rdata, 32'h7);
        chk(h_pos == '0 && v_pos == '0, "R7 display at origin", 32'(h_pos), 0);
        walk_frame(1'b1);

        // R10 read-to-clear, mask
        repeat (2) tick();
        rd_clear(d);
        chk(d[0] == 1'b1, "R10 flag set", d, 32'h1);
        chk(!irq, "R10 cleared by read", 32'(irq), 0);
        wr(4'd9, 32'h1);
        n = 0;
        while (!sof && n < 200) begin tick(); n++; end
        tick();
        chk(!irq, "R10 masked", 32'(irq), 0);
        wr(4'd8, 32'h1);
        chk(irq, "R10 enable shows flag", 32'(irq), 32'h1);
        rd_clear(d);
        chk(d[0] == 1'b1 && !irq, "R10 sticky while masked", d, 32'h1);

        // R5 polarity inversion
        wr(4'd4, 32'h0000_0503);
        chk(out_mode == 4'd5, "R11 out_mode kept", 32'(out_mode), 32'd5);
        n = 0;
        while (h_pos != '0 && n < 20) begin tick(); n++; end
        chk(hsync == 1'b0, "R5 hsync active low", 32'(hsync), 0);
        tick(); tick();
        chk(hsync == 1'b1, "R5 hsync idle high", 32'(hsync), 32'h1);

        // R7 shutdown in reverse order with one write
        wr(4'd6, 32'h7);
        n = 0;
        while (bus_rdata[2] && n < 200) begin tick(); n++; end
        chk(bus_rdata[2:0] == 3'b011, "R7 display off first", bus_rdata, 32'h3);
        chk(h_pos == '0 && v_pos == '0, "R7 display off at origin", 32'(h_pos), 0);
        n = 0;
        while (bus_rdata[1] && n < 200) begin tick(); n++; end
        chk(bus_rdata[2:0] == 3'b001, "R7 sync off before clock", bus_rdata, 32'h1);
        chk(hsync && vsync && !de, "R8 inactive inverted levels",
            {hsync, vsync, de}, 32'h6);
        tick();
        chk(bus_rdata[2:0] == 3'b000, "R6 clock off", bus_rdata, 0);
        repeat (4) tick();
        chk(h_pos == '0 && v_pos == '0, "R6 counters held", 32'(h_pos), 0);
        chk(pix_out == '0, "R8 pix off", 32'(pix_out), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule